// File: doc/BRIEF.md
# Configuration Register Protection Controller

This block holds the settings of a four-channel output module and guards them. A host reaches it through a simple synchronous bus: an 8-bit address, a write strobe, 16-bit write data and a combinational 16-bit read port. Every channel has three settings: a mode, an offset and a gain. Beside them sit four command and status registers. One is a global lock flag. One is a save command that needs a key. One is a per-channel restore command. One is a sticky error word that the host clears by writing ones.

The save command does not store anything itself. It raises a request to a non-volatile store and holds it until the store reports completion. It then shows a completion pattern until the host writes the register again. A restore puts a channel's three settings back to their parameter defaults one cycle after the command is accepted. While the lock flag is set, the block refuses restores and host writes to the channel settings, and it flags each refused restore in the error word.

Address map:

| Address | Register |
|---|---|
| 0x00+ch | mode of channel ch |
| 0x04+ch | offset of channel ch |
| 0x08+ch | gain of channel ch |
| 0x10 | lock flag, bit 0 |
| 0x11 | save command |
| 0x12 | restore command |
| 0x13 | error word |

Unmapped addresses read 0.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset, every mode and offset reads 0x0000 and every gain reads 0x03E8. The lock flag, the save command, the restore command and the error word all read 0x0000, and nv_save_req is low.
- R2: Writing 0x5678 to the save command (0x11) while no save is running raises nv_save_req on the next cycle, and the register then reads 0x5678.
- R3: One cycle after nv_save_done is high during a save, nv_save_req is low and the save command reads 0xFFFF.
- R4: Writing any value other than 0x5678 to the save command while no save is running leaves nv_save_req low, and the register reads 0x0000 from the next cycle.
- R5: While a save is running, writes to the save command are ignored. The register keeps reading 0x5678 and nv_save_req stays high until done.
- R6: Writing the restore command (0x12) while unlocked returns the mode, offset and gain of every channel whose bit (bit n = channel n, bits 0..3) is 1 to their defaults. The restore happens one cycle after the command reads back. Other channels keep their values, and bits 4..15 are dropped.
- R7: An accepted restore command reads back its channel bits for exactly one cycle and then reads 0x0000 by itself.
- R8: While the lock flag (0x10, bit 0) is 1, a restore command is not accepted. The restore register stays 0x0000 and all settings are unchanged.
- R9: A restore command refused under lock with at least one channel bit set sets bit 12 (0x1000) of the error word on the next cycle.
- R10: A high pulse on err_evt bits 0 (power), 1 (hardware), 2 (bound), 9 (mode setting), 11 (bound setting) or 13 (downstream link) sets the same bit of the error word (0x13). Several bits can be set at once. Bits 3..8, 10, 14 and 15 always read 0.
- R11: Error bits are sticky. A bit clears only when the host writes 1 to that bit of the error word, and a set event in the same cycle wins over the clear.
- R12: While the lock flag is 1, host writes to mode, offset and gain registers have no effect.
- R13: While unlocked, a write to a mode, offset or gain register reads back the written value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| err_evt | input | 16 | Error event pulses, one per error bit position |
| nv_save_req | output | 1 | Save request to the non-volatile store, held until done |
| nv_save_done | input | 1 | Store reports that the save has finished |

## Verification
Most internal state of this block is directly readable. A wrong channel setting, lock flag, pending restore mask or error bit therefore shows on bus_rdata in the first cycle the host addresses that register after the faulty edge. The reference model reads some register on every cycle and compares nv_save_req on every cycle. A stuck save sequencer shows at once on nv_save_req. A restore that fails to clear itself shows one cycle later, as a second reset of a channel the host has just rewritten.

// File: rtl/cfg_guard_pkg.sv
// Shared constants and types for the configuration protection controller.
// Assumes an 8-bit register address and a 16-bit error word layout.
package cfg_guard_pkg;

    localparam int ADDR_W = 8;

    // Command / status register addresses
    localparam logic [ADDR_W-1:0] ADDR_LOCK    = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_SAVE    = 8'h11;
    localparam logic [ADDR_W-1:0] ADDR_RESTORE = 8'h12;
    localparam logic [ADDR_W-1:0] ADDR_ERR     = 8'h13;

    // Channel setting field selector (address bits 3:2)
    typedef enum logic [1:0] {
        FLD_MODE   = 2'd0,
        FLD_OFFSET = 2'd1,
        FLD_GAIN   = 2'd2
    } cfg_field_e;

    // Save sequencer states
    typedef enum logic [1:0] {
        SV_IDLE = 2'd0,
        SV_BUSY = 2'd1,
        SV_DONE = 2'd2
    } save_state_e;

    // Error bits fed by outside events, and the bit for a refused restore
    localparam logic [15:0] ERR_EXT_MASK = 16'h2A07;
    localparam int          ERR_LOCK_BIT = 12;

endpackage

// File: rtl/cfg_chan_bank.sv
// Per-channel mode/offset/gain storage.
// A restore pulse forces a channel back to its defaults and wins over a
// same-cycle host write. Assumes wr_ch/wr_fld are already qualified.
module cfg_chan_bank
    import cfg_guard_pkg::*;
#(
    parameter int                NUM_CH     = 4,
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] DEF_MODE   = '0,
    parameter logic [DATA_W-1:0] DEF_OFFSET = '0,
    parameter logic [DATA_W-1:0] DEF_GAIN   = 16'h03E8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_ch,
    input  logic [1:0]                    wr_fld,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_CH-1:0]             restore,
    output logic [NUM_CH-1:0][DATA_W-1:0] mode_q,
    output logic [NUM_CH-1:0][DATA_W-1:0] offset_q,
    output logic [NUM_CH-1:0][DATA_W-1:0] gain_q
);

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            localparam logic [1:0] CH_ID = 2'(c);
            logic sel;
            assign sel = wr_en && (wr_ch == CH_ID);

            // Hold one channel's settings; reset/restore load defaults
            always_ff @(posedge clk) begin
                if (!rst_n || restore[c]) begin
                    mode_q[c]   <= DEF_MODE;
                    offset_q[c] <= DEF_OFFSET;
                    gain_q[c]   <= DEF_GAIN;
                end else if (sel) begin
                    case (wr_fld)
                        FLD_MODE:   mode_q[c]   <= wr_data;
                        FLD_OFFSET: offset_q[c] <= wr_data;
                        FLD_GAIN:   gain_q[c]   <= wr_data;
                        default:    ;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_save_seq.sv
// Keyed save sequencer. Only the key starts a save; the request is held
// until the store reports done; commands during a save are ignored.
// Assumes nv_done is only meaningful while the request is high.
module cfg_save_seq
    import cfg_guard_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] SAVE_KEY = 16'h5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              nv_done,
    output logic              nv_req,
    output logic [DATA_W-1:0] view
);

    save_state_e st;

    // Advance the save state on commands and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SV_IDLE;
        end else begin
            case (st)
                SV_BUSY: if (nv_done) st <= SV_DONE;
                default: if (cmd_wr)  st <= (cmd_data == SAVE_KEY) ? SV_BUSY : SV_IDLE;
            endcase
        end
    end

    // Present the command register value seen by the host
    always_comb begin
        case (st)
            SV_BUSY: view = SAVE_KEY;
            SV_DONE: view = '1;
            default: view = '0;
        endcase
    end

    assign nv_req = (st == SV_BUSY);

endmodule

// File: rtl/cfg_err_stat.sv
// Sticky error word. Events set bits, the host clears them by writing ones,
// and a set wins over a same-cycle clear. Undefined bits never latch.
module cfg_err_stat
    import cfg_guard_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ext_evt,
    input  logic              lock_hit,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] err_q
);

    localparam logic [DATA_W-1:0] LOCK_VEC = DATA_W'(1) << ERR_LOCK_BIT;

    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] clr_v;

    // Gather this cycle's set and clear vectors
    always_comb begin
        set_v = (ext_evt & DATA_W'(ERR_EXT_MASK)) | (lock_hit ? LOCK_VEC : '0);
        clr_v = clr_wr ? clr_data : '0;
    end

    // Update the sticky error bits
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_v) | set_v;
    end

endmodule

// File: rtl/cfg_guard_ctrl.sv
// Top of the configuration protection controller: address decode, lock
// flag, self-clearing restore command and read multiplexer.
// Assumes NUM_CH <= 4 and a 16-bit data path for the error layout.
module cfg_guard_ctrl
    import cfg_guard_pkg::*;
#(
    parameter int                NUM_CH     = 4,
    parameter int                DATA_W     = 16,
    parameter logic [DATA_W-1:0] DEF_MODE   = '0,
    parameter logic [DATA_W-1:0] DEF_OFFSET = '0,
    parameter logic [DATA_W-1:0] DEF_GAIN   = 16'h03E8,
    parameter logic [DATA_W-1:0] SAVE_KEY   = 16'h5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] err_evt,
    output logic              nv_save_req,
    input  logic              nv_save_done
);

    logic                          lock_q;
    logic [NUM_CH-1:0]             rst_pend;
    logic [NUM_CH-1:0][DATA_W-1:0] mode_q;
    logic [NUM_CH-1:0][DATA_W-1:0] offset_q;
    logic [NUM_CH-1:0][DATA_W-1:0] gain_q;
    logic [DATA_W-1:0]             save_view;
    logic [DATA_W-1:0]             err_q;

    logic cfg_hit, cfg_wr, lock_wr, save_wr, rest_wr, err_wr, lock_hit;

    // Decode the bus access
    always_comb begin
        cfg_hit  = (bus_addr[7:4] == 4'h0) && (bus_addr[3:2] != 2'd3)
                   && (int'(bus_addr[1:0]) < NUM_CH);
        cfg_wr   = bus_we && cfg_hit && !lock_q;
        lock_wr  = bus_we && (bus_addr == ADDR_LOCK);
        save_wr  = bus_we && (bus_addr == ADDR_SAVE);
        rest_wr  = bus_we && (bus_addr == ADDR_RESTORE);
        err_wr   = bus_we && (bus_addr == ADDR_ERR);
        lock_hit = rest_wr && lock_q && (|bus_wdata[NUM_CH-1:0]);
    end

    // Lock flag register
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (lock_wr) lock_q <= bus_wdata[0];
    end

    // Restore command: accepted only when unlocked, lives for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                  rst_pend <= '0;
        else if (rest_wr && !lock_q) rst_pend <= bus_wdata[NUM_CH-1:0];
        else                         rst_pend <= '0;
    end

    cfg_chan_bank #(
        .NUM_CH    (NUM_CH),
        .DATA_W    (DATA_W),
        .DEF_MODE  (DEF_MODE),
        .DEF_OFFSET(DEF_OFFSET),
        .DEF_GAIN  (DEF_GAIN)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_ch   (bus_addr[1:0]),
        .wr_fld  (bus_addr[3:2]),
        .wr_data (bus_wdata),
        .restore (rst_pend),
        .mode_q  (mode_q),
        .offset_q(offset_q),
        .gain_q  (gain_q)
    );

    cfg_save_seq #(
        .DATA_W  (DATA_W),
        .SAVE_KEY(SAVE_KEY)
    ) u_save (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (save_wr),
        .cmd_data(bus_wdata),
        .nv_done (nv_save_done),
        .nv_req  (nv_save_req),
        .view    (save_view)
    );

    cfg_err_stat #(
        .DATA_W(DATA_W)
    ) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_evt (err_evt),
        .lock_hit(lock_hit),
        .clr_wr  (err_wr),
        .clr_data(bus_wdata),
        .err_q   (err_q)
    );

    // Select the read data for the addressed register
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_LOCK:    bus_rdata = DATA_W'(lock_q);
            ADDR_SAVE:    bus_rdata = save_view;
            ADDR_RESTORE: bus_rdata = DATA_W'(rst_pend);
            ADDR_ERR:     bus_rdata = err_q;
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (cfg_hit && (int'(bus_addr[1:0]) == c)) begin
                        case (bus_addr[3:2])
                            FLD_MODE:   bus_rdata = mode_q[c];
                            FLD_OFFSET: bus_rdata = offset_q[c];
                            default:    bus_rdata = gain_q[c];
                        endcase
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/cfg_guard_chk.sv
// Property checker for cfg_guard_ctrl, attached by bind. Observes the bus,
// the save handshake, and the lock/restore/error/settings state.
module cfg_guard_chk
    import cfg_guard_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_we,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic                         nv_save_req,
    input logic                         nv_save_done,
    input logic                         lock_q,
    input logic [NUM_CH-1:0]            rst_pend,
    input logic [DATA_W-1:0]            err_q,
    input logic [3*NUM_CH*DATA_W-1:0]   cfg_flat
);

    logic save_wr, rest_wr, err_wr, key_hit;
    logic [DATA_W-1:0] keep_v;

    // Derive access qualifiers from the bus
    always_comb begin
        save_wr = bus_we && (bus_addr == ADDR_SAVE);
        rest_wr = bus_we && (bus_addr == ADDR_RESTORE);
        err_wr  = bus_we && (bus_addr == ADDR_ERR);
        key_hit = save_wr && (bus_wdata == 16'h5678);
        keep_v  = err_q & ~(err_wr ? bus_wdata : '0);
    end

    p_key_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_hit && !nv_save_req) |=> nv_save_req);

    p_done_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_save_req && nv_save_done) |=> !nv_save_req);

    p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_wr && !key_hit && !nv_save_req) |=> !nv_save_req);

    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_save_req && !nv_save_done) |=> nv_save_req);

    p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_pend != '0) && !rest_wr) |=> (rst_pend == '0));

    p_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_wr && lock_q) |=> (rst_pend == '0));

    p_lock_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_wr && lock_q && (|bus_wdata[NUM_CH-1:0])) |=> err_q[12]);

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_ERR) |-> ((bus_rdata & ~16'h3A07) == '0));

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_v != '0) |=> ((err_q & $past(keep_v)) == $past(keep_v)));

    p_locked_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && (rst_pend == '0)) |=> $stable(cfg_flat));

endmodule

bind cfg_guard_ctrl cfg_guard_chk #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .nv_save_req (nv_save_req),
    .nv_save_done(nv_save_done),
    .lock_q      (lock_q),
    .rst_pend    (rst_pend),
    .err_q       (err_q),
    .cfg_flat    ({mode_q, offset_q, gain_q})
);

// File: tb/tb_cfg_guard_ctrl.sv
`timescale 1ns/1ps
// Bench for cfg_guard_ctrl: behavioural reference model stepped every clock,
// bus_rdata and nv_save_req compared every cycle.
module tb_cfg_guard_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] err_evt = '0;
    logic        nv_save_req;
    logic        nv_save_done = 1'b0;

    cfg_guard_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_evt(err_evt),
        .nv_save_req(nv_save_req), .nv_save_done(nv_save_done)
    );

    always #5 clk = ~clk;

    // Reference model state
    logic [15:0] m_mode [4];
    logic [15:0] m_off  [4];
    logic [15:0] m_gain [4];
    logic        m_lock;
    logic [3:0]  m_pend;
    logic [15:0] m_err;
    int          m_save;          // 0 idle, 1 busy, 2 done

    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_req = "R1";

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_mode[c] = 16'h0000; m_off[c] = 16'h0000; m_gain[c] = 16'h03E8;
        end
        m_lock = 0; m_pend = 0; m_err = 0; m_save = 0;
    endtask

    function automatic logic [15:0] model_rd(input logic [7:0] a);
        if (a[7:4] == 0 && a[3:2] == 0) return m_mode[a[1:0]];
        if (a[7:4] == 0 && a[3:2] == 1) return m_off[a[1:0]];
        if (a[7:4] == 0 && a[3:2] == 2) return m_gain[a[1:0]];
        case (a)
            8'h10: return {15'b0, m_lock};
            8'h11: return (m_save == 1) ? 16'h5678 : (m_save == 2) ? 16'hFFFF : 16'h0000;
            8'h12: return {12'b0, m_pend};
            8'h13: return m_err;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_step(input logic [7:0] a, input logic w, input logic [15:0] d,
                              input logic [15:0] ev, input logic dn);
        logic [3:0]  n_pend;
        logic [15:0] set_v, clr_v;
        int          n_save;
        // channel settings: restore first, else unlocked write
        for (int c = 0; c < 4; c++) begin
            if (m_pend[c]) begin
                m_mode[c] = 16'h0000; m_off[c] = 16'h0000; m_gain[c] = 16'h03E8;
            end else if (w && !m_lock && a[7:4] == 0 && a[1:0] == c[1:0]) begin
                if (a[3:2] == 0) m_mode[c] = d;
                if (a[3:2] == 1) m_off[c]  = d;
                if (a[3:2] == 2) m_gain[c] = d;
            end
        end
        n_pend = (w && a == 8'h12 && !m_lock) ? d[3:0] : 4'h0;
        set_v  = (ev & 16'h2A07) | ((w && a == 8'h12 && m_lock && d[3:0] != 0) ? 16'h1000 : 16'h0);
        clr_v  = (w && a == 8'h13) ? d : 16'h0;
        m_err  = (m_err & ~clr_v) | set_v;
        n_save = m_save;
        if (m_save == 1) begin
            if (dn) n_save = 2;
        end else if (w && a == 8'h11) begin
            n_save = (d == 16'h5678) ? 1 : 0;
        end
        m_save = n_save;
        m_pend = n_pend;
        if (w && a == 8'h10) m_lock = d[0];
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, compare, then step the model at posedge
    task automatic cyc(input logic [7:0] a, input logic w, input logic [15:0] d,
                       input logic [15:0] ev, input logic dn);
        @(negedge clk);
        bus_addr = a; bus_we = w; bus_wdata = d; err_evt = ev; nv_save_done = dn;
        #1;
        check(bus_rdata, model_rd(a), $sformatf("rdata @%h", a));
        check({15'b0, nv_save_req}, {15'b0, m_save == 1}, "nv_save_req");
        @(posedge clk);
        model_step(a, w, d, ev, dn);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(a, 1'b0, 16'h0, 16'h0, 1'b0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        cyc(a, 1'b1, d, 16'h0, 1'b0);
    endtask

    task automatic rd_cfg_all();
        for (int c = 0; c < 4; c++) begin
            rd(8'(c)); rd(8'(4 + c)); rd(8'(8 + c));
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset values of every register
        cur_req = "R1";
        rd_cfg_all();
        rd(8'h10); rd(8'h11); rd(8'h12); rd(8'h13); rd(8'h3F);

        // R13 unlocked writes read back
        cur_req = "R13";
        for (int c = 0; c < 4; c++) begin
            wr(8'(c), 16'h0010 + 16'(c));
            wr(8'(4 + c), 16'hA000 + 16'(c));
            wr(8'(8 + c), 16'h5500 + 16'(c));
        end
        rd_cfg_all();

        // R6 restore channels 0 and 2 with reserved bits set; R7 self-clear
        cur_req = "R6";
        wr(8'h12, 16'hF005);
        cur_req = "R7";
        rd(8'h12); rd(8'h12);
        cur_req = "R6";
        rd_cfg_all();
        wr(8'h12, 16'h0008);
        rd(8'h0B); rd(8'h03); rd(8'h07); rd(8'h0B);
        wr(8'h03, 16'h0777); rd(8'h03);

        // R12 lock blocks setting writes
        cur_req = "R12";
        wr(8'h10, 16'hFFFF);
        rd(8'h10);
        wr(8'h01, 16'hDEAD); wr(8'h05, 16'hBEEF); wr(8'h09, 16'h1234);
        rd(8'h01); rd(8'h05); rd(8'h09);

        // R8 restore refused under lock; R9 error bit 12
        cur_req = "R8";
        wr(8'h12, 16'h000F);
        rd(8'h12);
        rd_cfg_all();
        cur_req = "R9";
        rd(8'h13);
        wr(8'h12, 16'h0000);
        rd(8'h13);

        // R11 write-one-to-clear and sticky
        cur_req = "R11";
        wr(8'h10, 16'h0000);
        wr(8'h13, 16'h0000); rd(8'h13);
        wr(8'h13, 16'h1000); rd(8'h13);

        // R10 event latching with reserved bits
        cur_req = "R10";
        cyc(8'h13, 1'b0, 16'h0, 16'hFFFF, 1'b0);
        rd(8'h13);
        cur_req = "R11";
        wr(8'h13, 16'h0005); rd(8'h13);
        cyc(8'h13, 1'b1, 16'h0002, 16'h0002, 1'b0);
        rd(8'h13);
        wr(8'h13, 16'hFFFF); rd(8'h13);
        cur_req = "R10";
        cyc(8'h13, 1'b0, 16'h0, 16'h0200, 1'b0);
        cyc(8'h13, 1'b0, 16'h0, 16'h0800, 1'b0);
        rd(8'h13);

        // R4 wrong key; R2 key; R5 commands during a save; R3 done
        cur_req = "R4";
        wr(8'h11, 16'h1234); rd(8'h11);
        wr(8'h11, 16'h5679); rd(8'h11);
        cur_req = "R2";
        wr(8'h11, 16'h5678); rd(8'h11);
        cur_req = "R5";
        wr(8'h11, 16'h0000); rd(8'h11);
        wr(8'h11, 16'h5678); rd(8'h11); rd(8'h11);
        cur_req = "R3";
        cyc(8'h11, 1'b0, 16'h0, 16'h0, 1'b1);
        rd(8'h11); rd(8'h11);
        cur_req = "R4";
        wr(8'h11, 16'h0001); rd(8'h11);
        cur_req = "R2";
        wr(8'h11, 16'h5678);
        for (int i = 0; i < 4; i++) rd(8'h11);
        cur_req = "R3";
        cyc(8'h00, 1'b0, 16'h0, 16'h0, 1'b1);
        rd(8'h11);
        cur_req = "R2";
        wr(8'h11, 16'h5678); rd(8'h11);
        cur_req = "R3";
        cyc(8'h11, 1'b0, 16'h0, 16'h0, 1'b1);
        rd(8'h11);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule